// File: doc/BRIEF.md
# Ring-Buffer Address Generator for Shared RAM

This block produces 20-bit RAM addresses for a byte FIFO placed in a region of shared memory. A base register gives the high part of every address. A write pointer, a read pointer and a temporary (look-ahead) pointer give the low part, which is the byte offset inside the buffer. A 3-bit size code selects the buffer size at run time. Codes 0 to 6 give a power of two from 32 to 2048 bytes. Code 7 gives a linear window of 2048 bytes, where the offset is added to the base with carry.

The client raises one request strobe per cycle: write, read or speculative read. In the same cycle the block shows the address to use on `acc_addr` and sets `acc_vld` if it accepted the request. No data passes through the block, so the request strobes are plain control pins and there is no valid/ready back-pressure. A request that cannot be served is dropped and sets a sticky error flag. A speculative read walks the temporary pointer ahead of the read pointer. A commit then moves the read pointer forward and frees the bytes that were consumed.

Top module: `ring_addr_gen`

## Requirements
- R1: After reset the size code is 6 (2048 bytes), the base and all pointers are zero, `fill` is 0, `empty` is 1, `full` is 0 and `err` is 0.
- R2: Size codes 0,1,2,3,4,5,6 give a capacity of 32,64,128,256,512,1024,2048 bytes. `full` rises only when `fill` equals that capacity.
- R3: With a bounded code and a size of 2^n bytes, `acc_addr` takes bits 19..n from the base register and bits n-1..0 from the pointer. Base bits n-1..4 have no effect. The base register holds only bits 19..4.
- R4: In a bounded mode each pointer steps from size-1 back to 0 and never carries into address bits at or above n.
- R5: With code 7, `acc_addr` equals the 16-byte-aligned base plus the 11-bit pointer, with carry into the base bits, and the capacity is 2048.
- R6: `empty` is 1 exactly when `fill` is 0. `fill` rises by one on an accepted write and falls by one on an accepted read.
- R7: A write while `full`, or a read while `empty`, gives `acc_vld`=0 and leaves `fill` and the pointers unchanged. It sets `err`, which stays at 1 until reset.
- R8: Only one operation is taken per cycle, in this priority: size write, commit, temp load, write, read, speculative read. Lower-priority requests in that cycle have no effect.
- R9: A temp load copies the read pointer into the temporary pointer. A speculative read returns the address at the temporary pointer and advances it without changing `fill`. It is refused (with `err`) once as many speculative reads are pending as `fill`.
- R10: A commit copies the temporary pointer into the read pointer and lowers `fill` by the number of pending speculative reads.
- R11: A normal read while speculative reads are pending is refused with `acc_vld`=0 and sets `err`. `fill` does not change.
- R12: A size write clears all pointers and `fill` from the next cycle on. The next write then uses offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the size code |
| cfg_size | input | 3 | New size code (0-6 bounded, 7 linear) |
| base_we | input | 1 | Write strobe for the base register |
| base_din | input | 16 | Base address bits 19..4 |
| wr_req | input | 1 | Write access request |
| rd_req | input | 1 | Read access request |
| spec_req | input | 1 | Speculative read through the temporary pointer |
| tmp_load | input | 1 | Copy the read pointer into the temporary pointer |
| tmp_commit | input | 1 | Copy the temporary pointer into the read pointer |
| acc_addr | output | 20 | RAM address for the accepted access (zero otherwise) |
| acc_vld | output | 1 | The access request in this cycle was accepted |
| fill | output | 12 | Bytes held in the buffer |
| full | output | 1 | Buffer holds its capacity |
| empty | output | 1 | Buffer holds no bytes |
| err | output | 1 | Sticky flag for a refused access |

## Verification
The assertions check on every cycle that the pointers stay inside the selected mask and that `fill` never exceeds the capacity. They also check that `full` and `empty` are never both set, that the error flag never drops, that refused writes and reads leave `fill` alone, that a bounded address keeps the base bits above the boundary, and that a size write empties the buffer. The bench scenarios show the exact address sequences: the wrap from the last offset to 0, the carry into the base in linear mode, the capacity of each size, the priority order among requests in the same cycle, and the speculative-read and commit sequence with its refusals.

// File: rtl/ring_addr_gen_pkg.sv
package ring_addr_gen_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_CFG,
    OP_COMMIT,
    OP_LOAD,
    OP_WR,
    OP_RD,
    OP_SPEC
  } rag_op_e;
endpackage

// File: rtl/ring_addr_gen_size_dec.sv
module ring_addr_gen_size_dec #(
  parameter int CODE_W   = 3,
  parameter int MIN_LOG2 = 5,
  parameter int PTR_W    = 11
) (
  input  logic [CODE_W-1:0] code,
  output logic [PTR_W-1:0]  mask,
  output logic [PTR_W:0]    cap,
  output logic              linear
);
  localparam logic [CODE_W-1:0] LIN_CODE = '1;

  assign linear = (code == LIN_CODE);

  // one mask bit per offset bit: set when the bit lies below the boundary
  for (genvar i = 0; i < PTR_W; i++) begin : g_mask
    assign mask[i] = linear || (i < (MIN_LOG2 + int'(code)));
  end

  assign cap = {1'b0, mask} + (PTR_W+1)'(1);
endmodule

// File: rtl/ring_addr_gen_ptr.sv
module ring_addr_gen_ptr #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (clr)      q_nxt = '0;
    else if (ld)  q_nxt = ld_val & mask;
    else if (inc) q_nxt = (q + W'(1)) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/ring_addr_gen_compose.sv
module ring_addr_gen_compose #(
  parameter int ADDR_W   = 20,
  parameter int PTR_W    = 11,
  parameter int BASE_LSB = 4
) (
  input  logic [ADDR_W-1:BASE_LSB] base,
  input  logic [PTR_W-1:0]         ptr,
  input  logic [PTR_W-1:0]         mask,
  input  logic                     linear,
  output logic [ADDR_W-1:0]        addr
);
  logic [ADDR_W-1:0] base_full;
  logic [ADDR_W-1:0] mask_w;
  logic [ADDR_W-1:0] ptr_w;

  assign base_full = {base, {BASE_LSB{1'b0}}};
  assign mask_w    = ADDR_W'(mask);
  assign ptr_w     = ADDR_W'(ptr);

  always_comb begin
    if (linear) addr = base_full + ptr_w;
    else        addr = (base_full & ~mask_w) | (ptr_w & mask_w);
  end
endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen #(
  parameter int ADDR_W   = 20,
  parameter int CODE_W   = 3,
  parameter int MIN_LOG2 = 5,
  parameter int BASE_LSB = 4,
  localparam int PTR_W   = MIN_LOG2 + (1 << CODE_W) - 2,
  localparam int CNT_W   = PTR_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CODE_W-1:0]        cfg_size,
  input  logic                     base_we,
  input  logic [ADDR_W-1:BASE_LSB] base_din,
  input  logic                     wr_req,
  input  logic                     rd_req,
  input  logic                     spec_req,
  input  logic                     tmp_load,
  input  logic                     tmp_commit,
  output logic [ADDR_W-1:0]        acc_addr,
  output logic                     acc_vld,
  output logic [CNT_W-1:0]         fill,
  output logic                     full,
  output logic                     empty,
  output logic                     err
);
  import ring_addr_gen_pkg::*;

  localparam logic [CODE_W-1:0] RST_CODE = CODE_W'((1 << CODE_W) - 2);

  logic [CODE_W-1:0]        size_q;
  logic [ADDR_W-1:BASE_LSB] base_q;
  logic [CNT_W-1:0]         cnt_q, cnt_nxt;
  logic [CNT_W-1:0]         spec_q, spec_nxt;
  logic                     err_q;
  logic [PTR_W-1:0]         mask;
  logic [CNT_W-1:0]         cap;
  logic                     linear;
  logic [PTR_W-1:0]         wr_q, rd_q, tmp_q, sel_ptr;
  logic [ADDR_W-1:0]        comp_addr;
  rag_op_e                  op;
  logic                     refuse;
  logic                     clr_all;

  ring_addr_gen_size_dec #(.CODE_W(CODE_W), .MIN_LOG2(MIN_LOG2), .PTR_W(PTR_W)) u_dec (
    .code(size_q), .mask(mask), .cap(cap), .linear(linear)
  );

  assign full  = (cnt_q == cap);
  assign empty = (cnt_q == '0);

  // single operation per cycle, fixed priority
  always_comb begin
    op     = OP_IDLE;
    refuse = 1'b0;
    if (cfg_we)          op = OP_CFG;
    else if (tmp_commit) op = OP_COMMIT;
    else if (tmp_load)   op = OP_LOAD;
    else if (wr_req) begin
      if (!full) op = OP_WR;
      else       refuse = 1'b1;
    end else if (rd_req) begin
      if (!empty && spec_q == '0) op = OP_RD;
      else                        refuse = 1'b1;
    end else if (spec_req) begin
      if (spec_q < cnt_q) op = OP_SPEC;
      else                refuse = 1'b1;
    end
  end

  assign clr_all = (op == OP_CFG);

  ring_addr_gen_ptr #(.W(PTR_W)) u_wr_ptr (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .ld(1'b0), .ld_val('0),
    .inc(op == OP_WR), .mask(mask), .q(wr_q)
  );

  ring_addr_gen_ptr #(.W(PTR_W)) u_rd_ptr (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .ld(op == OP_COMMIT), .ld_val(tmp_q),
    .inc(op == OP_RD), .mask(mask), .q(rd_q)
  );

  ring_addr_gen_ptr #(.W(PTR_W)) u_tmp_ptr (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .ld(op == OP_LOAD), .ld_val(rd_q),
    .inc(op == OP_SPEC), .mask(mask), .q(tmp_q)
  );

  always_comb begin
    cnt_nxt  = cnt_q;
    spec_nxt = spec_q;
    unique case (op)
      OP_CFG:    begin cnt_nxt = '0;               spec_nxt = '0; end
      OP_COMMIT: begin cnt_nxt = cnt_q - spec_q;   spec_nxt = '0; end
      OP_LOAD:   spec_nxt = '0;
      OP_WR:     cnt_nxt = cnt_q + CNT_W'(1);
      OP_RD:     cnt_nxt = cnt_q - CNT_W'(1);
      OP_SPEC:   spec_nxt = spec_q + CNT_W'(1);
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= RST_CODE;
      base_q <= '0;
      cnt_q  <= '0;
      spec_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (op == OP_CFG) size_q <= cfg_size;
      if (base_we)      base_q <= base_din;
      cnt_q  <= cnt_nxt;
      spec_q <= spec_nxt;
      if (refuse)       err_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (op)
      OP_WR:   sel_ptr = wr_q;
      OP_RD:   sel_ptr = rd_q;
      OP_SPEC: sel_ptr = tmp_q;
      default: sel_ptr = '0;
    endcase
  end

  ring_addr_gen_compose #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .BASE_LSB(BASE_LSB)) u_comp (
    .base(base_q), .ptr(sel_ptr), .mask(mask), .linear(linear), .addr(comp_addr)
  );

  assign acc_vld  = (op == OP_WR) || (op == OP_RD) || (op == OP_SPEC);
  assign acc_addr = acc_vld ? comp_addr : '0;
  assign fill     = cnt_q;
  assign err      = err_q;
endmodule

// File: rtl/ring_addr_gen_chk.sv
module ring_addr_gen_chk #(
  parameter int ADDR_W   = 20,
  parameter int PTR_W    = 11,
  parameter int BASE_LSB = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic                     wr_req,
  input logic                     rd_req,
  input logic                     tmp_load,
  input logic                     tmp_commit,
  input logic                     acc_vld,
  input logic [ADDR_W-1:0]        acc_addr,
  input logic [PTR_W:0]           fill,
  input logic                     full,
  input logic                     empty,
  input logic                     err,
  input logic [PTR_W-1:0]         wr_q,
  input logic [PTR_W-1:0]         rd_q,
  input logic [PTR_W-1:0]         tmp_q,
  input logic [PTR_W-1:0]         mask,
  input logic [PTR_W:0]           cap,
  input logic                     linear,
  input logic [ADDR_W-1:BASE_LSB] base_q
);
  logic ctl_busy;
  assign ctl_busy = cfg_we || tmp_commit || tmp_load;

  AST_WR_PTR_IN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q & ~mask) == '0); // R4
  AST_RD_PTR_IN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q & ~mask) == '0); // R4
  AST_TMP_PTR_IN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (tmp_q & ~mask) == '0); // R9
  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= cap); // R2
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R7
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !ctl_busy) |=> ($stable(fill) && err)); // R7
  AST_EMPTY_READ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req && !wr_req && !ctl_busy) |=> ($stable(fill) && err)); // R7
  AST_BASE_ABOVE_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !linear) |->
      (((acc_addr ^ {base_q, {BASE_LSB{1'b0}}}) & ~ADDR_W'(mask)) == '0)); // R3
  AST_CFG_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (empty && wr_q == '0 && rd_q == '0)); // R12
endmodule

bind ring_addr_gen ring_addr_gen_chk #(
  .ADDR_W(ADDR_W), .PTR_W(PTR_W), .BASE_LSB(BASE_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .wr_req(wr_req), .rd_req(rd_req),
  .tmp_load(tmp_load), .tmp_commit(tmp_commit), .acc_vld(acc_vld), .acc_addr(acc_addr),
  .fill(fill), .full(full), .empty(empty), .err(err), .wr_q(wr_q), .rd_q(rd_q),
  .tmp_q(tmp_q), .mask(mask), .cap(cap), .linear(linear), .base_q(base_q)
);

// File: tb/sim_ring_addr_gen.sv
module sim_ring_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_size = '0;
  logic        base_we = 1'b0;
  logic [19:4] base_din = '0;
  logic        wr_req = 1'b0, rd_req = 1'b0, spec_req = 1'b0;
  logic        tmp_load = 1'b0, tmp_commit = 1'b0;
  logic [19:0] acc_addr;
  logic        acc_vld;
  logic [11:0] fill;
  logic        full, empty, err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic        s_vld;
  logic [19:0] s_addr;

  always #2 clk = ~clk;

  ring_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_size(cfg_size),
    .base_we(base_we), .base_din(base_din), .wr_req(wr_req), .rd_req(rd_req),
    .spec_req(spec_req), .tmp_load(tmp_load), .tmp_commit(tmp_commit),
    .acc_addr(acc_addr), .acc_vld(acc_vld), .fill(fill), .full(full),
    .empty(empty), .err(err)
  );

  // {op[1:0] (1 write, 2 read), expected valid, 0, expected address}
  localparam logic [23:0] VEC [8] = '{
    24'h6ABCC0, 24'h6ABCC1, 24'h6ABCC2, 24'hAABCC0,
    24'hAABCC1, 24'hAABCC2, 24'h800000, 24'h6ABCC3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; access outputs are captured before the rising edge
  task automatic cyc(input logic cf, input logic [2:0] sz, input logic w, input logic r,
                     input logic s, input logic ld, input logic cm);
    @(negedge clk);
    cfg_we = cf; cfg_size = sz; wr_req = w; rd_req = r; spec_req = s;
    tmp_load = ld; tmp_commit = cm;
    #1;
    s_vld = acc_vld; s_addr = acc_addr;
    @(posedge clk);
    #1;
    cfg_we = 1'b0; wr_req = 1'b0; rd_req = 1'b0; spec_req = 1'b0;
    tmp_load = 1'b0; tmp_commit = 1'b0;
  endtask

  task automatic wr();   cyc(0, 0, 1, 0, 0, 0, 0); endtask
  task automatic rd();   cyc(0, 0, 0, 1, 0, 0, 0); endtask
  task automatic spec(); cyc(0, 0, 0, 0, 1, 0, 0); endtask
  task automatic set_size(input logic [2:0] c); cyc(1, c, 0, 0, 0, 0, 0); endtask

  task automatic set_base(input logic [15:0] b);
    @(negedge clk);
    base_we = 1'b1; base_din = b;
    @(posedge clk);
    #1;
    base_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 fill", 32'(fill), 0);
    wr();
    chk("R1 first write addr", 32'(s_addr), 0);
    chk("R1 first write valid", 32'(s_vld), 1);

    // table: 32-byte buffer, base A19..A4 = ABCD (R3, R6, R7)
    do_reset();
    set_size(3'd0);
    set_base(16'hABCD);
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][23:22] == 2'd1) wr(); else rd();
      chk("R3 table valid", 32'(s_vld), 32'(VEC[i][21]));
      if (VEC[i][21]) chk("R3 table addr", 32'(s_addr), 32'(VEC[i][19:0]));
    end
    chk("R6 table fill", 32'(fill), 1);
    chk("R7 table err after empty read", 32'(err), 1);

    // R3 / R5: bounded clears base bits below the boundary, linear adds with carry
    do_reset();
    set_size(3'd6);
    set_base(16'h000F);
    wr();
    chk("R3 2048 base bits dropped", 32'(s_addr), 32'h00000);
    set_size(3'd0);
    wr();
    chk("R3 32-byte base masked", 32'(s_addr), 32'h000E0);
    set_size(3'd7);
    wr();
    chk("R5 linear first addr", 32'(s_addr), 32'h000F0);
    for (int i = 0; i < 15; i++) wr();
    wr();
    chk("R5 linear carry into base", 32'(s_addr), 32'h00100);

    // R2 / R4 / R6 / R7: fill, wrap and overflow on a 32-byte buffer
    do_reset();
    set_size(3'd0);
    set_base(16'h0100);
    for (int i = 0; i < 31; i++) wr();
    chk("R6 not full at 31", 32'(full), 0);
    wr();
    chk("R4 last offset", 32'(s_addr), 32'h0101F);
    chk("R2 full at 32", 32'(full), 1);
    chk("R2 fill 32", 32'(fill), 32);
    wr();
    chk("R7 write when full valid", 32'(s_vld), 0);
    chk("R7 write when full fill", 32'(fill), 32);
    chk("R7 err set", 32'(err), 1);
    rd();
    chk("R6 first read addr", 32'(s_addr), 32'h01000);
    for (int i = 0; i < 30; i++) rd();
    rd();
    chk("R4 last read addr", 32'(s_addr), 32'h0101F);
    chk("R6 empty after drain", 32'(empty), 1);
    wr();
    chk("R4 write wraps to 0", 32'(s_addr), 32'h01000);
    chk("R7 err still set", 32'(err), 1);
    set_size(3'd2);
    chk("R12 cfg clears fill", 32'(fill), 0);
    for (int i = 0; i < 127; i++) wr();
    chk("R2 128 not full at 127", 32'(full), 0);
    wr();
    chk("R2 128 full at 128", 32'(full), 1);

    // R8 / R12: priority and reconfiguration
    do_reset();
    set_size(3'd0);
    wr();
    cyc(0, 0, 1, 1, 0, 0, 0);
    chk("R8 write wins over read", 32'(s_addr), 1);
    chk("R8 fill after write-wins", 32'(fill), 2);
    cyc(1, 3'd0, 1, 0, 0, 0, 0);
    chk("R8 cfg blocks write", 32'(s_vld), 0);
    chk("R12 fill zero", 32'(fill), 0);
    chk("R12 empty", 32'(empty), 1);
    wr();
    chk("R12 write restarts at 0", 32'(s_addr), 0);

    // R9 / R10 / R11: speculative reads and commit
    do_reset();
    set_size(3'd0);
    for (int i = 0; i < 4; i++) wr();
    cyc(0, 0, 0, 0, 0, 1, 0);
    spec();
    chk("R9 spec addr 0", 32'(s_addr), 0);
    spec();
    chk("R9 spec addr 1", 32'(s_addr), 1);
    chk("R9 fill unchanged", 32'(fill), 4);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R10 commit fill", 32'(fill), 2);
    rd();
    chk("R10 read after commit", 32'(s_addr), 2);
    cyc(0, 0, 0, 0, 0, 1, 0);
    spec();
    chk("R9 spec after reload", 32'(s_addr), 3);
    spec();
    chk("R9 spec beyond fill refused", 32'(s_vld), 0);
    chk("R9 err set", 32'(err), 1);
    rd();
    chk("R11 read with pending spec refused", 32'(s_vld), 0);
    chk("R11 fill unchanged", 32'(fill), 1);

    finish_run();
  end
endmodule